// File: doc/BRIEF.md
# Two-Tone Tag Identifier Demodulator

This block decodes the reply of a low-frequency transponder that signals with two carrier tones. A comparator output, sampled once per `sample_en` tick (nominally 2 MHz), is watched for low-to-high transitions. Every sixteenth transition ends one bit period. The number of samples that period took is then classified as the slower tone (a 1), the faster tone (a 0), or neither.

Classified bits stream least significant first into a 128-bit window. The window is wiped whenever a period fits neither tone. After every decision the window is searched for a framing pattern whose leading and trailing bytes agree. On a hit the block presents the 64-bit identifier, the 16-bit check field, a rewritable-tag flag and an ident-consistency flag, marks them with a one-cycle strobe, and starts the search afresh.

Top module: `fsk_id_demod`

## Requirements
- R1: The input is sampled only on clocks with `sample_en` high. A rising transition is a sample of 1 whose previous sample was 0. Clocks with `sample_en` low change nothing, whatever `comp_in` does.
- R2: Every 16th rising transition is a decision point. The measurement is the number of samples from the previous decision point (exclusive) to this one (inclusive).
- R3: A measurement from 249 to 269 inclusive decodes as 1. This is the slow-tone count of 259 with a margin of 11, exclusive at both ends.
- R4: A measurement from 228 to 248 inclusive decodes as 0. This is the fast-tone count of 238 with a margin of 11, exclusive at both ends.
- R5: Any other measurement, such as 227 or 270 and beyond, clears all 128 window bits.
- R6: A decoded bit enters window bit 127 while the window shifts one place toward bit 0, so the first received bit ends in bit 0.
- R7: A frame is accepted at a decision point when window bits [22:0] equal 23'h7E0000 and bits [23:16] equal bits [111:104]. No other condition raises `frame_valid`.
- R8: On acceptance, `frame_valid` is high for exactly one clock, the clock after the deciding sample. At the same time `data_word` takes window bits [87:24] and `crc_word` takes bits [103:88]. All outputs hold until the next acceptance.
- R9: `rw_tag` takes window bit 111. `ident_ok` is 1 only when `rw_tag` is 1 and window bits [126:112] equal `data_word[14:0]`. Data bit 15 plays no part.
- R10: Acceptance clears the window and the transition count, so a frame that follows at once is decoded too.
- R11: While `rst_n` is low at a clock edge, all outputs go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_en | input | 1 | Sample tick qualifier |
| comp_in | input | 1 | Comparator output of the antenna signal |
| frame_valid | output | 1 | One-cycle strobe on an accepted frame |
| data_word | output | 64 | Identifier from the last accepted frame |
| crc_word | output | 16 | Check field from the last accepted frame |
| rw_tag | output | 1 | Rewritable-tag flag of the last frame |
| ident_ok | output | 1 | Ident field agrees with the identifier |

## Verification
The same sample can complete a frame and also need to restart the search. On that sample the final bit is shifted in, acceptance fires, and the window and transition count must be cleared, with the clear taking precedence over the shift. The bench sends the frames back to back, so the first decision of the next frame falls sixteen transitions after an acceptance. It then checks that each frame in the stream produces exactly one strobe, with the right fields. One frame is also delivered through a sample tick that drops out periodically while the comparator toggles, and the tone periods in all frames are placed on the edges of the acceptance windows.

// File: rtl/fsk_id_demod.sv
module fsk_id_demod #(
  parameter int SAMPLE_HZ      = 2_000_000,
  parameter int TONE_SLOW_HZ   = 123_200,
  parameter int TONE_FAST_HZ   = 134_200,
  parameter int CYCLES_PER_BIT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sample_en,
  input  logic        comp_in,
  output logic        frame_valid,
  output logic [63:0] data_word,
  output logic [15:0] crc_word,
  output logic        rw_tag,
  output logic        ident_ok
);
  localparam int SLOW_CNT = (CYCLES_PER_BIT * SAMPLE_HZ) / TONE_SLOW_HZ;
  localparam int FAST_CNT = (CYCLES_PER_BIT * SAMPLE_HZ) / TONE_FAST_HZ;
  localparam int MARGIN   = (SLOW_CNT - FAST_CNT + 1) / 2;
  localparam int SPAN_MAX = SLOW_CNT + MARGIN;
  localparam int SPAN_W   = $clog2(SPAN_MAX + 1);
  localparam int EDGE_W   = $clog2(CYCLES_PER_BIT);
  localparam int WIN_W    = 128;

  logic              prev_s;
  logic [EDGE_W-1:0] edge_cnt;
  logic [SPAN_W-1:0] span;
  logic [WIN_W-1:0]  win;

  wire rise   = sample_en & ~prev_s & comp_in;
  wire decide = rise && (edge_cnt == EDGE_W'(CYCLES_PER_BIT - 1));

  wire [SPAN_W-1:0] meas = (span == SPAN_W'(SPAN_MAX)) ? span : span + 1'b1;

  wire is_one  = (meas > SPAN_W'(SLOW_CNT - MARGIN)) && (meas < SPAN_W'(SLOW_CNT + MARGIN));
  wire is_zero = (meas > SPAN_W'(FAST_CNT - MARGIN)) && (meas < SPAN_W'(FAST_CNT + MARGIN));

  wire [WIN_W-1:0] win_next = (is_one | is_zero) ? {is_one, win[WIN_W-1:1]} : '0;

  wire hit = decide
          && (win_next[22:0] == 23'h7E0000)
          && (win_next[23:16] == win_next[111:104]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_s      <= 1'b1;
      edge_cnt    <= '0;
      span        <= '0;
      win         <= '0;
      frame_valid <= 1'b0;
      data_word   <= '0;
      crc_word    <= '0;
      rw_tag      <= 1'b0;
      ident_ok    <= 1'b0;
    end else begin
      frame_valid <= hit;
      if (sample_en) begin
        prev_s <= comp_in;
        if (decide)                         span <= '0;
        else if (span != SPAN_W'(SPAN_MAX)) span <= span + 1'b1;
        if (rise) edge_cnt <= decide ? '0 : edge_cnt + 1'b1;
        if (decide) win <= hit ? '0 : win_next;
      end
      if (hit) begin
        data_word <= win_next[87:24];
        crc_word  <= win_next[103:88];
        rw_tag    <= win_next[111];
        ident_ok  <= win_next[111] && (win_next[126:112] == win_next[38:24]);
      end
    end
  end
endmodule

module fsk_id_demod_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sample_en,
  input logic        frame_valid,
  input logic [63:0] data_word,
  input logic [15:0] crc_word,
  input logic        rw_tag,
  input logic        ident_ok
);
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  a_r8_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> ($stable(data_word) && $stable(crc_word) && $stable(rw_tag) && $stable(ident_ok)));

  a_r9_ident_needs_rw: assert property (@(posedge clk) disable iff (!rst_n)
    ident_ok |-> rw_tag);

  a_r1_strobe_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_valid) |-> $past(sample_en));
endmodule

bind fsk_id_demod fsk_id_demod_chk u_chk (.*);

// File: tb/tb_fsk_id_demod.sv
module tb_fsk_id_demod;
  logic clk = 1'b0, rst_n = 1'b0, sample_en = 1'b0, comp_in = 1'b0;
  logic        frame_valid;
  logic [63:0] data_word;
  logic [15:0] crc_word;
  logic        rw_tag, ident_ok;

  fsk_id_demod dut (.clk(clk), .rst_n(rst_n), .sample_en(sample_en), .comp_in(comp_in),
                    .frame_valid(frame_valid), .data_word(data_word), .crc_word(crc_word),
                    .rw_tag(rw_tag), .ident_ok(ident_ok));

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [63:0] d;
    logic [15:0] c;
    logic        rw;
    logic        id;
  } exp_t;

  exp_t expq[$];
  int n_cmp = 0, n_bad = 0, n_valid = 0, samp_i = 0;
  bit gapping = 1'b0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // R1: a gap cycle holds sample_en low while comp_in shows the wrong level
  task automatic put(input bit v);
    @(negedge clk);
    if (gapping && (samp_i % 16 == 15)) begin
      sample_en = 1'b0;
      comp_in   = ~v;
      @(negedge clk);
    end
    sample_en = 1'b1;
    comp_in   = v;
    samp_i++;
  endtask

  // 16 transition intervals totalling t samples; each interval opens with its rising edge
  task automatic group(input int t);
    for (int k = 0; k < 16; k++) begin
      int c, h;
      c = t / 16 + ((k < t % 16) ? 1 : 0);
      h = c / 2;
      repeat (h) put(1'b1);
      repeat (c - h) put(1'b0);
    end
  endtask

  function automatic int one_len(input int i);
    case (i % 3) 0: return 249; 1: return 259; default: return 269; endcase
  endfunction

  function automatic int zero_len(input int i);
    case (i % 3) 0: return 228; 1: return 238; default: return 248; endcase
  endfunction

  function automatic logic [127:0] build(input logic [63:0] d, input logic [15:0] c,
                                         input logic rw, input logic [14:0] id,
                                         input logic [7:0] endb);
    logic [127:0] w;
    w = '0;
    w[22:17]   = 6'h3F;
    w[23]      = rw;
    w[87:24]   = d;
    w[103:88]  = c;
    w[111:104] = endb;
    w[126:112] = id;
    w[127]     = 1'b1;
    return w;
  endfunction

  // R6: bit 0 of the frame image goes out first
  task automatic send_frame(input logic [127:0] w, input int abort_at);
    for (int i = 0; i < 128; i++) begin
      if (i == abort_at) group(270);
      else if (w[i])     group(one_len(i));
      else               group(zero_len(i));
    end
  endtask

  task automatic expect_frame(input logic [63:0] d, input logic [15:0] c,
                              input logic rw, input logic [14:0] id);
    exp_t e;
    e.d  = d;
    e.c  = c;
    e.rw = rw;
    e.id = rw && (id == d[14:0]);
    expq.push_back(e);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && frame_valid && !done) begin
      n_valid++;
      if (expq.size() == 0) begin
        check(1'b0, "R7", "unexpected frame_valid", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(data_word == e.d, "R8", "data_word", data_word, e.d);
        check(crc_word == e.c, "R8", "crc_word", 64'(crc_word), 64'(e.c));
        check(rw_tag == e.rw, "R9", "rw_tag", 64'(rw_tag), 64'(e.rw));
        check(ident_ok == e.id, "R9", "ident_ok", 64'(ident_ok), 64'(e.id));
      end
    end
  end

  initial begin
    repeat (199_000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    summary();
  end

  initial begin
    logic [127:0] w;
    repeat (4) @(negedge clk);
    // R11: reset state
    check(frame_valid == 1'b0, "R11", "frame_valid", 64'(frame_valid), 64'd0);
    check(data_word == 64'd0, "R11", "data_word", data_word, 64'd0);
    check(crc_word == 16'd0, "R11", "crc_word", 64'(crc_word), 64'd0);
    check(rw_tag == 1'b0, "R11", "rw_tag", 64'(rw_tag), 64'd0);
    check(ident_ok == 1'b0, "R11", "ident_ok", 64'(ident_ok), 64'd0);
    rst_n = 1'b1;

    // R2: fifteen lone intervals align decisions to group starts, then a noise group (R5)
    repeat (10) put(1'b0);
    for (int k = 0; k < 15; k++) begin
      repeat (8) put(1'b1);
      repeat (8) put(1'b0);
    end
    group(200);

    // F1 read-only tag with a gapped sample tick (R1, R3, R4, R7)
    gapping = 1'b1;
    expect_frame(64'h0123_4567_89AB_CDEF, 16'hBEEF, 1'b0, 15'h5A5A);
    w = build(64'h0123_4567_89AB_CDEF, 16'hBEEF, 1'b0, 15'h5A5A, 8'h7E);
    send_frame(w, -1);
    gapping = 1'b0;

    // F2 back to back: rewritable, ident matches on 15 bits while data bit 15 differs (R9, R10)
    expect_frame(64'hFEDC_BA98_7654_B210, 16'h1D0F, 1'b1, 15'h3210);
    w = build(64'hFEDC_BA98_7654_B210, 16'h1D0F, 1'b1, 15'h3210, 8'hFE);
    send_frame(w, -1);

    // F3 rewritable with ident mismatch (R9)
    expect_frame(64'h0F0F_1234_5678_A5C3, 16'h4321, 1'b1, 15'h25C2);
    w = build(64'h0F0F_1234_5678_A5C3, 16'h4321, 1'b1, 15'h25C2, 8'hFE);
    send_frame(w, -1);

    // F4 start/end byte disagree: no acceptance (R7)
    w = build(64'hAAAA_5555_0000_FFFF, 16'h0001, 1'b1, 15'h7FFF, 8'h7E);
    send_frame(w, -1);

    // F5 out-of-window period near the end wipes the window: no acceptance (R5)
    w = build(64'h1111_2222_3333_4444, 16'h5555, 1'b0, 15'h0000, 8'h7E);
    send_frame(w, 120);

    group(200);
    repeat (20) @(negedge clk);
    done = 1'b1;

    check(n_valid == 3, "R10", "accepted frame count", 64'(n_valid), 64'd3);
    check(expq.size() == 0, "R7", "frames left unseen", 64'(expq.size()), 64'd0);
    check(data_word == 64'h0F0F_1234_5678_A5C3, "R8", "held data_word", data_word,
          64'h0F0F_1234_5678_A5C3);
    check(crc_word == 16'h4321, "R8", "held crc_word", 64'(crc_word), 64'h4321);
    summary();
  end
endmodule